// File: doc/BRIEF.md
# Presettable Cascadable Down Counter

This block is a synchronous down counter for frequency division. A parameter selects modulo-16 (binary) or modulo-10 (BCD) counting. The count steps down by one on a rising edge of the count clock while the hold line is low. It also steps down on a falling edge of the hold line while the count clock is high, so the hold line can serve as a second, negative-edge clock. Both lines are sampled by the fast system clock through two-flop synchronizers, and the edges are found from those samples.

Two level-sensitive overrides act asynchronously on the visible count. A clear input forces the count to zero. A load input forces the count to an external preset value. Clear takes priority over load, and both take priority over any pending step. A decoded zero flag, gated by a chain input, marks the terminal count. The usual single-stage use wires the zero flag back to the load input, which gives a divide-by-N. Stages chain with no extra gates: the zero flag of the more significant stage feeds the chain input of the less significant one.

A small state machine tracks the operating phase, which keeps the zero decode free of glitches around a preset. The states are `ST_CLEAR` (clear active, or just released), `ST_PRESET` (load was seen at the last system-clock edge) and `ST_COUNT` (normal counting). There are three transitions, and each applies from any state. Clear asserted goes asynchronously to `ST_CLEAR`. Load high at an edge goes to `ST_PRESET`. Load low at an edge goes to `ST_COUNT`.

Top module: `presettable_down_counter`

## Requirements
- R1: With `hold` low, each rising edge of `cnt_clk` lowers `count` by exactly one.
- R2: With `cnt_clk` high, each falling edge of `hold` lowers `count` by exactly one.
- R3: A `cnt_clk` edge while `hold` is high, or a `hold` edge while `cnt_clk` is low, leaves `count` unchanged.
- R4: While `clr` is high, `count` is 0 at once, whatever the other inputs do and with no system-clock edge needed.
- R5: While `clr` is high, `zero_out` equals `load` OR `chain`.
- R6: With `clr` low and `load` high, `count` equals `load_val` at once. `zero_out` stays low while `load` is high and for the first system-clock cycle after it falls.
- R7: Otherwise, with `clr` low, `zero_out` is high exactly when `count` is 0 and `chain` is high.
- R8: Stepping down from 0 gives 15 when `BCD`=0 and 9 when `BCD`=1.
- R9: With `BCD`=1, a preset above 9 (for example 12) is loaded unchanged and then counts down normally (12 to 11).
- R10: While `load` is held high, count edges do not change `count`, because the preset takes priority over any pending step.
- R11: With `zero_out` fed back to `load` and `chain` high, `zero_out` pulses once every N count edges for a preset N. N runs from 1 to 15 in binary mode and from 1 to 9 in BCD mode.
- R12: In two cascaded binary stages, the upper stage's `zero_out` drives the lower stage's `chain`. The lower stage's `zero_out` reloads both stages, and the upper stage only sees count edges that arrive while the lower count is 0. With presets upper=2 and lower=3, the lower `zero_out` then pulses once every 35 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Fast system clock that samples everything |
| clr | input | 1 | Asynchronous clear, active high |
| cnt_clk | input | 1 | Count clock; a rising edge steps the count |
| hold | input | 1 | Hold line; high blocks count-clock edges, and its falling edge steps the count |
| load | input | 1 | Asynchronous preset enable, active high |
| load_val | input | WIDTH | Preset value |
| chain | input | 1 | Chain input that gates the zero flag |
| count | output | WIDTH | Current count |
| zero_out | output | 1 | Decoded terminal-count flag |

## Verification
Two things can compete for the same system-clock edge: a synchronized count edge reaching the step logic, and a preset or clear override. The bench provokes this in two ways. It holds `load` high across a full count-clock pulse, and it raises `clr` between two system-clock edges while the count is nonzero. It judges the outcome at the ports: the count must show the preset or zero and never the stepped value. The divide-by-N and cascade runs feed `zero_out` back to `load`. In those runs the reload and the next count edge fall close together, and the bench checks that the zero pulses come at exactly the expected edge numbers.

// File: rtl/dd_pkg.sv
package dd_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR  = 2'd0,
        ST_PRESET = 2'd1,
        ST_COUNT  = 2'd2
    } run_state_e;

endpackage

// File: rtl/dd_sync.sv
module dd_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             sys_clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int TOTAL = WIDTH * STAGES;

    logic [TOTAL-1:0] shift_q;

    // Datapath synchronizer: no reset, the flops settle from the inputs.
    always_ff @(posedge sys_clk) begin
        shift_q <= {shift_q[TOTAL-WIDTH-1:0], d};
    end

    assign q = shift_q[TOTAL-1 -: WIDTH];
endmodule

// File: rtl/dd_edge.sv
module dd_edge (
    input  logic sys_clk,
    input  logic clk_lvl,
    input  logic inh_lvl,
    output logic step
);
    logic clk_d;
    logic inh_d;

    always_ff @(posedge sys_clk) begin
        clk_d <= clk_lvl;
        inh_d <= inh_lvl;
    end

    logic clk_rise;
    logic inh_fall;

    assign clk_rise = clk_lvl & ~clk_d;
    assign inh_fall = inh_d & ~inh_lvl;

    // Rising count clock with hold low, or falling hold with count clock high.
    assign step = (clk_rise & ~inh_lvl) | (inh_fall & clk_lvl);
endmodule

// File: rtl/dd_core.sv
module dd_core
    import dd_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter bit BCD   = 1'b0
) (
    input  logic             sys_clk,
    input  logic             clr,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             chain,
    input  logic             step,
    output logic [WIDTH-1:0] count,
    output logic             zero_out
);
    localparam int               MODULUS  = BCD ? 10 : (1 << WIDTH);
    localparam logic [WIDTH-1:0] WRAP_VAL = WIDTH'(MODULUS - 1);

    run_state_e       state_q;
    run_state_e       state_d;
    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] cnt_d;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR:  state_d = load ? ST_PRESET : ST_COUNT;
            ST_PRESET: state_d = load ? ST_PRESET : ST_COUNT;
            ST_COUNT:  state_d = load ? ST_PRESET : ST_COUNT;
            default:   state_d = ST_CLEAR;
        endcase
    end

    // Count datapath: preset beats a pending step.
    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (step) begin
            cnt_d = (cnt_q == '0) ? WRAP_VAL : cnt_q - 1'b1;
        end
    end

    // State register.
    always_ff @(posedge sys_clk or posedge clr) begin
        if (clr) begin
            state_q <= ST_CLEAR;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs with level-sensitive overrides.
    always_comb begin
        if (clr) begin
            count    = '0;
            zero_out = load | chain;
        end else if (load) begin
            count    = load_val;
            zero_out = 1'b0;
        end else begin
            count    = cnt_q;
            zero_out = chain && (cnt_q == '0) && (state_q != ST_PRESET);
        end
    end
endmodule

// File: rtl/presettable_down_counter.sv
module presettable_down_counter #(
    parameter int WIDTH       = 4,
    parameter bit BCD         = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic             sys_clk,
    input  logic             clr,
    input  logic             cnt_clk,
    input  logic             hold,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             chain,
    output logic [WIDTH-1:0] count,
    output logic             zero_out
);
    logic [1:0] lvl_s;
    logic       step;

    dd_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .sys_clk (sys_clk),
        .d       ({cnt_clk, hold}),
        .q       (lvl_s)
    );

    dd_edge u_edge (
        .sys_clk (sys_clk),
        .clk_lvl (lvl_s[1]),
        .inh_lvl (lvl_s[0]),
        .step    (step)
    );

    dd_core #(
        .WIDTH (WIDTH),
        .BCD   (BCD)
    ) u_core (
        .sys_clk  (sys_clk),
        .clr      (clr),
        .load     (load),
        .load_val (load_val),
        .chain    (chain),
        .step     (step),
        .count    (count),
        .zero_out (zero_out)
    );
endmodule

// File: rtl/dd_checker.sv
module dd_checker #(
    parameter int WIDTH = 4,
    parameter bit BCD   = 1'b0
) (
    input logic             sys_clk,
    input logic             clr,
    input logic             load,
    input logic [WIDTH-1:0] load_val,
    input logic             chain,
    input logic [WIDTH-1:0] count,
    input logic             zero_out
);
    localparam logic [WIDTH-1:0] TOP_VAL = BCD ? WIDTH'(9) : {WIDTH{1'b1}};

    always @(negedge sys_clk) begin
        if (clr === 1'b1) begin
            AST_CLR_COUNT: assert (count == '0); // R4
            AST_CLR_FLAG: assert (zero_out == (load | chain)); // R5
        end
    end

    AST_STEP_DOWN: assert property (@(posedge sys_clk) disable iff (clr)
        (!load && !$past(load) && count != $past(count) && $past(count) != '0)
        |-> count == WIDTH'($past(count) - 1'b1)); // R1

    AST_WRAP: assert property (@(posedge sys_clk) disable iff (clr)
        (!load && !$past(load) && count != $past(count) && $past(count) == '0)
        |-> count == TOP_VAL); // R8

    AST_PRESET_FLAG: assert property (@(posedge sys_clk) disable iff (clr)
        (load || ($past(load) && !$past(clr))) |-> !zero_out); // R6

    AST_ZERO_DECODE: assert property (@(posedge sys_clk) disable iff (clr)
        (zero_out && !load) |-> (count == '0 && chain)); // R7

    AST_LOAD_PRIORITY: assert property (@(posedge sys_clk) disable iff (clr)
        (load && $past(load) && load_val == $past(load_val)) |-> count == $past(count)); // R10
endmodule

bind presettable_down_counter dd_checker #(
    .WIDTH (WIDTH),
    .BCD   (BCD)
) u_chk (
    .sys_clk  (sys_clk),
    .clr      (clr),
    .load     (load),
    .load_val (load_val),
    .chain    (chain),
    .count    (count),
    .zero_out (zero_out)
);

// File: tb/sim_presettable_down_counter.sv
module sim_presettable_down_counter;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_PULSE = 8;

    logic       sys_clk = 1'b0;
    logic       clr = 1'b1;
    logic       cnt_clk = 1'b0;
    logic       hold = 1'b0;
    logic       hold_u = 1'b1;
    logic       chain = 1'b0;
    logic       fb = 1'b0;
    logic       load_drv = 1'b0;
    logic [3:0] lv0 = 4'd0;
    logic [3:0] lv1 = 4'd0;
    logic       fbl0 = 1'b0, fbl1 = 1'b0, fbl2 = 1'b0;
    logic       z0_d = 1'b0, z1_d = 1'b0, z2_d = 1'b0;
    int         rise0 = 0, rise1 = 0, rise2 = 0;
    int         n_chk = 0, n_fail = 0;

    logic [3:0] c0, c1, c2, c3;
    logic       z0, z1, z2, z3;
    logic       load0, load1;

    always #(CLK_PERIOD / 2) sys_clk = ~sys_clk;

    assign load0 = fb ? fbl0 : load_drv;
    assign load1 = fb ? fbl1 : load_drv;

    presettable_down_counter #(.WIDTH(4), .BCD(1'b0)) u0 (
        .sys_clk(sys_clk), .clr(clr), .cnt_clk(cnt_clk), .hold(hold),
        .load(load0), .load_val(lv0), .chain(chain), .count(c0), .zero_out(z0));

    presettable_down_counter #(.WIDTH(4), .BCD(1'b1)) u1 (
        .sys_clk(sys_clk), .clr(clr), .cnt_clk(cnt_clk), .hold(hold),
        .load(load1), .load_val(lv1), .chain(chain), .count(c1), .zero_out(z1));

    // Cascade: u2 lower stage, u3 upper stage.
    presettable_down_counter #(.WIDTH(4), .BCD(1'b0)) u2 (
        .sys_clk(sys_clk), .clr(clr), .cnt_clk(cnt_clk), .hold(1'b0),
        .load(fbl2), .load_val(4'd3), .chain(z3), .count(c2), .zero_out(z2));

    presettable_down_counter #(.WIDTH(4), .BCD(1'b0)) u3 (
        .sys_clk(sys_clk), .clr(clr), .cnt_clk(cnt_clk), .hold(hold_u),
        .load(fbl2), .load_val(4'd2), .chain(1'b1), .count(c3), .zero_out(z3));

    // Sample zero flags, count rises, then update registered feedback.
    always @(negedge sys_clk) begin
        if (z0 && !z0_d) rise0 = rise0 + 1;
        if (z1 && !z1_d) rise1 = rise1 + 1;
        if (z2 && !z2_d) rise2 = rise2 + 1;
        z0_d = z0;
        z1_d = z1;
        z2_d = z2;
        fbl0 = z0;
        fbl1 = z1;
        fbl2 = z2;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge sys_clk);
    endtask

    task automatic pulse();
        @(negedge sys_clk);
        cnt_clk = 1'b1;
        wait_cyc(HALF_PULSE);
        cnt_clk = 1'b0;
        wait_cyc(HALF_PULSE / 2);
        hold_u = (c2 != 4'd0);
        wait_cyc(HALF_PULSE / 2);
    endtask

    task automatic do_load(input logic [3:0] v0, input logic [3:0] v1);
        @(negedge sys_clk);
        lv0 = v0;
        lv1 = v1;
        load_drv = 1'b1;
        wait_cyc(2);
        load_drv = 1'b0;
        wait_cyc(3);
    endtask

    task automatic t_reset();
        @(negedge sys_clk);
        clr = 1'b1; chain = 1'b0; load_drv = 1'b0; fb = 1'b0;
        wait_cyc(3);
        chk(c0 == 4'd0, "R4 count under clear", c0, 0);
        chk(z0 == 1'b0, "R5 flag load=0 chain=0", z0, 0);
        chain = 1'b1;
        #1 chk(z0 == 1'b1, "R5 flag chain=1", z0, 1);
        chain = 1'b0; load_drv = 1'b1; lv0 = 4'd9;
        #1 chk(z0 == 1'b1, "R5 flag load=1", z0, 1);
        chk(c0 == 4'd0, "R4 clear beats load", c0, 0);
        load_drv = 1'b0;
        pulse();
        chk(c0 == 4'd0, "R4 edges ignored under clear", c0, 0);
        @(negedge sys_clk);
        chain = 1'b1;
        clr = 1'b0;
        wait_cyc(4);
    endtask

    task automatic t_preset();
        @(negedge sys_clk);
        lv0 = 4'd6;
        load_drv = 1'b1;
        #1 chk(c0 == 4'd6, "R6 immediate preset", c0, 6);
        wait_cyc(2);
        chk(z0 == 1'b0, "R6 flag low while loading", z0, 0);
        load_drv = 1'b0;
        wait_cyc(3);
        chk(c0 == 4'd6, "R6 preset retained", c0, 6);
    endtask

    task automatic t_steps();
        hold = 1'b0;
        pulse();
        chk(c0 == 4'd5, "R1 rising count clock", c0, 5);
        hold = 1'b1;
        wait_cyc(4);
        pulse();
        chk(c0 == 4'd5, "R3 clock edge under hold", c0, 5);
        hold = 1'b0;
        wait_cyc(6);
        chk(c0 == 4'd5, "R3 hold edge with clock low", c0, 5);
        hold = 1'b1;
        wait_cyc(4);
        cnt_clk = 1'b1;
        wait_cyc(HALF_PULSE);
        chk(c0 == 4'd5, "R3 clock rise with hold high", c0, 5);
        hold = 1'b0;
        wait_cyc(HALF_PULSE);
        chk(c0 == 4'd4, "R2 falling hold", c0, 4);
        cnt_clk = 1'b0;
        wait_cyc(HALF_PULSE);
        chk(c0 == 4'd4, "R2 single step", c0, 4);
    endtask

    task automatic t_wrap();
        do_load(4'd0, 4'd0);
        chk(z0 == 1'b1, "R7 zero with chain", z0, 1);
        chk(z1 == 1'b1, "R7 zero with chain bcd", z1, 1);
        @(negedge sys_clk);
        chain = 1'b0;
        #1 chk(z0 == 1'b0, "R7 zero gated by chain", z0, 0);
        chain = 1'b1;
        pulse();
        chk(c0 == 4'd15, "R8 binary wrap", c0, 15);
        chk(c1 == 4'd9, "R8 bcd wrap", c1, 9);
        chk(z0 == 1'b0, "R7 nonzero flag", z0, 0);
    endtask

    task automatic t_bcd_high();
        do_load(4'd3, 4'd12);
        chk(c1 == 4'd12, "R9 bcd preset above nine", c1, 12);
        pulse();
        chk(c1 == 4'd11, "R9 bcd counts from twelve", c1, 11);
    endtask

    task automatic t_priority();
        @(negedge sys_clk);
        lv0 = 4'd7;
        load_drv = 1'b1;
        pulse();
        chk(c0 == 4'd7, "R10 load beats step", c0, 7);
        pulse();
        chk(c0 == 4'd7, "R10 load beats second step", c0, 7);
        load_drv = 1'b0;
        wait_cyc(3);
        @(negedge sys_clk);
        #2 clr = 1'b1;
        #1 chk(c0 == 4'd0, "R4 asynchronous clear", c0, 0);
        wait_cyc(2);
        clr = 1'b0;
        wait_cyc(4);
    endtask

    task automatic t_divide(input bit use_bcd, input int n);
        @(negedge sys_clk);
        fb = 1'b1;
        chain = 1'b1;
        hold = 1'b0;
        if (use_bcd) lv1 = 4'(n); else lv0 = 4'(n);
        clr = 1'b1;
        wait_cyc(2);
        clr = 1'b0;
        wait_cyc(6);
        @(posedge sys_clk);
        rise0 = 0;
        rise1 = 0;
        for (int i = 1; i <= 3 * n; i++) begin
            pulse();
            if (use_bcd)
                chk(rise1 == i / n, "R11 bcd divide period", rise1, i / n);
            else
                chk(rise0 == i / n, "R11 binary divide period", rise0, i / n);
        end
        @(negedge sys_clk);
        fb = 1'b0;
    endtask

    task automatic t_cascade();
        @(negedge sys_clk);
        hold = 1'b0;
        clr = 1'b1;
        wait_cyc(2);
        clr = 1'b0;
        wait_cyc(6);
        hold_u = (c2 != 4'd0);
        wait_cyc(4);
        @(posedge sys_clk);
        rise2 = 0;
        for (int i = 1; i <= 70; i++) begin
            pulse();
            chk(rise2 == i / 35, "R12 cascade period", rise2, i / 35);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_preset();
        t_steps();
        t_wrap();
        t_bcd_high();
        t_priority();
        for (int n = 1; n <= 15; n++) t_divide(1'b0, n);
        for (int n = 1; n <= 9; n++) t_divide(1'b1, n);
        t_cascade();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule